// File: doc/BRIEF.md
# AC/DC Boundary-Scan Test Receiver

This block is the digital model of the test receiver that sits behind an input pin whose channel may be AC-coupled. A fast sampling clock delivers a multi-bit input level together with a valid strobe. The receiver turns that level into one logic bit. The boundary-scan cell then takes that bit at capture time. There are two ways of deciding the bit. In DC mode the bit is simply whether the level reaches a reference. In AC mode a hysteresis detector looks for edges that leave a band around the reference. An edge above the band gives 1, an edge below it gives 0, and movement inside the band is ignored.

The reference is a register. It is loaded from the sampled level when test software asks for it, so the DC threshold comes from a level measured at test start. The TAP signals (the test clock and the two state strobes for Capture-DR and Update-DR) are synchronised into the sampling clock domain. On the falling test-clock edge in Update-DR, the detector is re-seeded from the level present at launch, so no edge left over from an earlier pattern can be captured. On the rising test-clock edge in Capture-DR, the detector's bit is registered onto the capture output.

Top module: `acdc_test_rx`

## Requirements
- R1: After synchronous reset, both `det_bit_o` and `capture_bit_o` are 0, and the reference holds the parameter `REF_RESET` (default 128).
- R2: A cycle with `init_ref_i` and `sample_valid_i` both high loads the reference from `sample_level_i`. The comparison in that same cycle still uses the old reference, and the new value applies from the next cycle.
- R3: In DC mode (`ac_mode_i` = 0), each valid sample sets `det_bit_o` on the next clock edge to 1 when sample >= reference and to 0 otherwise.
- R4: In AC mode (`ac_mode_i` = 1), a valid sample strictly greater than reference + `hyst_i` sets `det_bit_o` to 1.
- R5: In AC mode, a valid sample strictly less than reference - `hyst_i` clears `det_bit_o` to 0.
- R6: In AC mode, a valid sample inside the closed band [reference - hyst, reference + hyst] leaves `det_bit_o` unchanged, including at both band edges.
- R7: Levels presented while `sample_valid_i` is low have no effect on `det_bit_o` or on the reference.
- R8: A falling `tck_i` edge seen while `update_dr_i` is high re-seeds `det_bit_o` to (level >= reference), in either mode. The level used is the sample of that cycle when it is valid, and otherwise the last valid sample. The re-seed takes priority over a crossing decision in the same cycle.
- R9: A rising `tck_i` edge seen while `capture_dr_i` is high loads `capture_bit_o` with the `det_bit_o` value held before that clock edge, so a crossing arriving in the same cycle is not captured.
- R10: Test-clock edges without `capture_dr_i` high leave `capture_bit_o` unchanged.
- R11: The band limits are computed without wraparound. reference + hyst above the top of the level range can never be exceeded, and reference - hyst below zero can never be undershot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the test clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid_i | input | 1 | Marks `sample_level_i` as a new valid sample |
| sample_level_i | input | LVL_W (8) | Sampled input level, unsigned |
| ac_mode_i | input | 1 | 0 = DC level test, 1 = AC edge test |
| init_ref_i | input | 1 | Load reference from the valid sample this cycle |
| hyst_i | input | LVL_W (8) | Half-width of the hysteresis band |
| tck_i | input | 1 | Test clock, asynchronous to `clk` |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| det_bit_o | output | 1 | Current detector decision |
| capture_bit_o | output | 1 | Bit handed to the boundary-scan cell |

## Verification
Two pairs of events can land on the same sampling-clock edge, and each pair is provoked on purpose. In the first pair, a capture edge meets an above-band sample. The test clock is raised with the capture strobe held, and the sample is timed to arrive exactly on the edge where the synchronised rise is acted on. The check then expects the old detector value on the capture output and the new value on the detector. In the second pair, an Update-DR launch meets an in-band sample. The sample is placed on the launch edge and its level lies between the reference and the lower band limit, so a hysteresis hold and a re-seed give opposite answers; only the re-seed answer passes.

// File: rtl/acdc_rx_pkg.sv
package acdc_rx_pkg;

    parameter int LVL_W = 8;

    typedef logic [LVL_W-1:0]        level_t;
    typedef logic signed [LVL_W+1:0] wide_t;

    typedef enum logic {
        MODE_DC = 1'b0,
        MODE_AC = 1'b1
    } rx_mode_e;

    typedef struct packed {
        wide_t hi;
        wide_t lo;
    } band_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic capture;
        logic update;
    } tap_evt_t;

    function automatic wide_t widen(input level_t v);
        return wide_t'({2'b00, v});
    endfunction

    function automatic band_t make_band(input level_t ref_lvl, input level_t hyst);
        band_t b;
        b.hi = widen(ref_lvl) + widen(hyst);
        b.lo = widen(ref_lvl) - widen(hyst);
        return b;
    endfunction

    function automatic logic dc_bit(input level_t s, input level_t ref_lvl);
        return (s >= ref_lvl);
    endfunction

    function automatic logic ac_bit(input logic cur, input level_t s, input band_t b);
        logic r;
        if (widen(s) > b.hi)
            r = 1'b1;
        else if (widen(s) < b.lo)
            r = 1'b0;
        else
            r = cur;
        return r;
    endfunction

endpackage

// File: rtl/acdc_rx_tap_sync.sv
module acdc_rx_tap_sync
    import acdc_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tck_i,
    input  logic     capture_st_i,
    input  logic     update_st_i,
    output tap_evt_t evt_o
);
    localparam int NSIG  = 3;
    localparam int I_TCK = 0;
    localparam int I_CAP = 1;
    localparam int I_UPD = 2;

    logic [NSIG-1:0]             raw;
    logic [STAGES-1:0][NSIG-1:0] chain_q;
    logic [NSIG-1:0]             synced;
    logic                        tck_prev_q;

    assign raw    = {update_st_i, capture_st_i, tck_i};
    assign synced = chain_q[STAGES-1];

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) tck_prev_q <= 1'b0;
        else     tck_prev_q <= synced[I_TCK];
    end

    always_comb begin
        evt_o.rise    = synced[I_TCK] & ~tck_prev_q;
        evt_o.fall    = ~synced[I_TCK] & tck_prev_q;
        evt_o.capture = synced[I_CAP];
        evt_o.update  = synced[I_UPD];
    end

    a_r9_single_edge_kind: assert property (@(posedge clk) disable iff (rst)
        evt_o.rise |=> !evt_o.rise);

endmodule

// File: rtl/acdc_rx_ref.sv
module acdc_rx_ref
    import acdc_rx_pkg::*;
#(
    parameter level_t REF_RESET = level_t'(128)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   init_ref_i,
    input  logic   valid_i,
    input  level_t sample_i,
    output level_t ref_o
);
    level_t ref_q;

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= REF_RESET;
        else if (init_ref_i && valid_i)
            ref_q <= sample_i;
    end

    assign ref_o = ref_q;

    a_r2_ref_loads_sample: assert property (@(posedge clk) disable iff (rst)
        (init_ref_i && valid_i) |=> (ref_o == $past(sample_i)));

    a_r7_ref_holds_without_valid: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(ref_o));

endmodule

// File: rtl/acdc_rx_detect.sv
module acdc_rx_detect
    import acdc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_mode_e mode_i,
    input  logic     valid_i,
    input  level_t   sample_i,
    input  level_t   ref_i,
    input  level_t   hyst_i,
    input  logic     launch_i,
    output logic     det_o
);
    logic   det_q;
    level_t last_q;
    level_t launch_lvl;
    band_t  band;
    logic   det_next;

    assign band       = make_band(ref_i, hyst_i);
    assign launch_lvl = valid_i ? sample_i : last_q;

    always_comb begin
        det_next = det_q;
        if (launch_i) begin
            det_next = dc_bit(launch_lvl, ref_i);
        end else if (valid_i) begin
            unique case (mode_i)
                MODE_DC: det_next = dc_bit(sample_i, ref_i);
                MODE_AC: det_next = ac_bit(det_q, sample_i, band);
                default: det_next = det_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q  <= 1'b0;
            last_q <= '0;
        end else begin
            det_q <= det_next;
            if (valid_i) last_q <= sample_i;
        end
    end

    assign det_o = det_q;

    a_r4_above_band_sets: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_AC && valid_i && !launch_i && widen(sample_i) > band.hi)
        |=> det_o);

    a_r5_below_band_clears: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_AC && valid_i && !launch_i && widen(sample_i) < band.lo)
        |=> !det_o);

    a_r6_in_band_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_AC && valid_i && !launch_i &&
         widen(sample_i) <= band.hi && widen(sample_i) >= band.lo)
        |=> $stable(det_o));

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !launch_i) |=> $stable(det_o));

    a_r8_launch_high_seed: assert property (@(posedge clk) disable iff (rst)
        (launch_i && valid_i && sample_i >= ref_i) |=> det_o);

endmodule

// File: rtl/acdc_rx_capture.sv
module acdc_rx_capture
    import acdc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tap_evt_t evt_i,
    input  logic     det_i,
    output logic     cap_o
);
    logic cap_q;
    logic take;

    assign take = evt_i.rise && evt_i.capture;

    always_ff @(posedge clk) begin
        if (rst)       cap_q <= 1'b0;
        else if (take) cap_q <= det_i;
    end

    assign cap_o = cap_q;

    a_r9_capture_takes_prior_det: assert property (@(posedge clk) disable iff (rst)
        take |=> (cap_o == $past(det_i)));

    a_r10_no_capture_holds: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(cap_o));

endmodule

// File: rtl/acdc_test_rx.sv
module acdc_test_rx
    import acdc_rx_pkg::*;
#(
    parameter level_t REF_RESET   = level_t'(128),
    parameter int     SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_valid_i,
    input  logic [LVL_W-1:0] sample_level_i,
    input  logic             ac_mode_i,
    input  logic             init_ref_i,
    input  logic [LVL_W-1:0] hyst_i,
    input  logic             tck_i,
    input  logic             capture_dr_i,
    input  logic             update_dr_i,
    output logic             det_bit_o,
    output logic             capture_bit_o
);
    tap_evt_t evt;
    level_t   ref_lvl;
    logic     launch;
    logic     det;
    rx_mode_e mode;

    assign mode   = rx_mode_e'(ac_mode_i);
    assign launch = evt.fall && evt.update;

    acdc_rx_tap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .tck_i        (tck_i),
        .capture_st_i (capture_dr_i),
        .update_st_i  (update_dr_i),
        .evt_o        (evt)
    );

    acdc_rx_ref #(.REF_RESET(REF_RESET)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .init_ref_i (init_ref_i),
        .valid_i    (sample_valid_i),
        .sample_i   (sample_level_i),
        .ref_o      (ref_lvl)
    );

    acdc_rx_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mode),
        .valid_i  (sample_valid_i),
        .sample_i (sample_level_i),
        .ref_i    (ref_lvl),
        .hyst_i   (hyst_i),
        .launch_i (launch),
        .det_o    (det)
    );

    acdc_rx_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt),
        .det_i (det),
        .cap_o (capture_bit_o)
    );

    assign det_bit_o = det;

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!det_bit_o && !capture_bit_o));

endmodule

// File: tb/acdc_test_rx_tb_top.sv
`timescale 1ns/100ps
module acdc_test_rx_tb_top;
    import acdc_rx_pkg::*;

    localparam real HALF = 2.5;

    typedef struct {
        string req;
        bit    is_cap;
        bit    val;
    } exp_t;

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    logic   sample_valid_i = 1'b0;
    level_t sample_level_i = '0;
    logic   ac_mode_i = 1'b0;
    logic   init_ref_i = 1'b0;
    level_t hyst_i = level_t'(16);
    logic   tck_i = 1'b0;
    logic   capture_dr_i = 1'b0;
    logic   update_dr_i = 1'b0;
    logic   det_bit_o;
    logic   capture_bit_o;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #(HALF) clk = ~clk;

    acdc_test_rx dut_i (
        .clk            (clk),
        .rst            (rst),
        .sample_valid_i (sample_valid_i),
        .sample_level_i (sample_level_i),
        .ac_mode_i      (ac_mode_i),
        .init_ref_i     (init_ref_i),
        .hyst_i         (hyst_i),
        .tck_i          (tck_i),
        .capture_dr_i   (capture_dr_i),
        .update_dr_i    (update_dr_i),
        .det_bit_o      (det_bit_o),
        .capture_bit_o  (capture_bit_o)
    );

    // monitor: 1 ns after each falling clock edge, pop and compare
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                bit   act;
                e   = sb_q.pop_front();
                act = e.is_cap ? capture_bit_o : det_bit_o;
                n_checks++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: %s actual=%0b expected=%0b", e.req,
                             e.is_cap ? "capture_bit_o" : "det_bit_o", act, e.val);
                end
            end
        end
    end

    task automatic expect_det(input string req, input bit v);
        exp_t e;
        e.req = req; e.is_cap = 1'b0; e.val = v;
        sb_q.push_back(e);
    endtask

    task automatic expect_cap(input string req, input bit v);
        exp_t e;
        e.req = req; e.is_cap = 1'b1; e.val = v;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_sample(input int lvl, input bit load_ref);
        sample_valid_i = 1'b1;
        sample_level_i = level_t'(lvl);
        init_ref_i     = load_ref;
        @(negedge clk);
        sample_valid_i = 1'b0;
        init_ref_i     = 1'b0;
    endtask

    task automatic tck_cycle(input bit cap, input bit upd);
        capture_dr_i = cap;
        update_dr_i  = upd;
        tck_i        = 1'b1;
        idle(5);
        tck_i = 1'b0;
        idle(5);
        capture_dr_i = 1'b0;
        update_dr_i  = 1'b0;
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        expect_det("R1", 1'b0);
        expect_cap("R1", 1'b0);
        idle(1);

        // DC mode, reference 128
        drive_sample(200, 1'b0); expect_det("R3", 1'b1);
        drive_sample(127, 1'b0); expect_det("R3", 1'b0);
        drive_sample(128, 1'b0); expect_det("R3", 1'b1);

        // R7: levels without valid are ignored
        sample_level_i = level_t'(10);
        idle(4);
        expect_det("R7", 1'b1);
        idle(1);

        // R2: load reference 60 (this cycle still compares against 128)
        drive_sample(60, 1'b1); expect_det("R2", 1'b0);
        drive_sample(61, 1'b0); expect_det("R2", 1'b1);

        // R9 / R10 capture behaviour
        tck_cycle(1'b1, 1'b0); expect_cap("R9", 1'b1);
        drive_sample(59, 1'b0); expect_det("R3", 1'b0);
        tck_cycle(1'b0, 1'b0); expect_cap("R10", 1'b1);
        tck_cycle(1'b1, 1'b0); expect_cap("R9", 1'b0);

        // AC mode, reference back to 128, hyst 16: band [112,144]
        ac_mode_i = 1'b1;
        drive_sample(128, 1'b1);
        drive_sample(100, 1'b0); expect_det("R5", 1'b0);
        drive_sample(140, 1'b0); expect_det("R6", 1'b0);
        drive_sample(144, 1'b0); expect_det("R6", 1'b0);
        drive_sample(145, 1'b0); expect_det("R4", 1'b1);
        drive_sample(115, 1'b0); expect_det("R6", 1'b1);
        drive_sample(112, 1'b0); expect_det("R6", 1'b1);
        drive_sample(111, 1'b0); expect_det("R5", 1'b0);

        // R8: launch re-seeds from last valid level (130 >= 128)
        drive_sample(130, 1'b0); expect_det("R6", 1'b0);
        tck_cycle(1'b0, 1'b1); expect_det("R8", 1'b1);

        // R8: launch coincides with an in-band sample 125 -> seed 0 wins over hold
        drive_sample(120, 1'b0); expect_det("R6", 1'b1);
        update_dr_i = 1'b1;
        tck_i = 1'b1;
        idle(5);
        tck_i = 1'b0;
        idle(2);
        drive_sample(125, 1'b0);
        expect_det("R8", 1'b0);
        idle(3);
        update_dr_i = 1'b0;
        idle(1);

        // R9: capture coincides with an above-band sample
        capture_dr_i = 1'b1;
        tck_i = 1'b1;
        idle(2);
        drive_sample(200, 1'b0);
        expect_cap("R9", 1'b0);
        expect_det("R4", 1'b1);
        idle(3);
        tck_i = 1'b0;
        idle(3);
        capture_dr_i = 1'b0;
        idle(1);

        // R11 upper saturation: reference 250, band [234,266]
        drive_sample(250, 1'b1);
        drive_sample(100, 1'b0); expect_det("R5", 1'b0);
        drive_sample(255, 1'b0); expect_det("R11", 1'b0);

        // R11 lower saturation: reference 5, band [-11,21]
        drive_sample(5, 1'b1);
        drive_sample(200, 1'b0); expect_det("R4", 1'b1);
        drive_sample(0, 1'b0);   expect_det("R11", 1'b1);
        idle(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule